// File: doc/BRIEF.md
# Minimal Byte-Coded Processor Core

This block is a small sequential processor. It fetches 32-bit instruction words from a word-addressed program memory with a one-cycle synchronous read, and runs a seven-opcode instruction set. The set can stop with an exit code, read a byte from a character input, send a register's low byte to a character output, subtract an 8-bit immediate from a 64-bit register while setting a zero flag, and branch relative to the current instruction, either always or depending on that flag.

Each instruction moves through fetch, decode, execute and write-back/PC update, one state per cycle. The execute state waits as long as a character transfer is not accepted. The register file sits in a synchronous-read memory, so it can map onto block RAM. A typical use is a byte filter program: it copies input characters to the output until it sees an end marker, then it stops.

Top module: `cpu_core`

## Requirements
- R1: An instruction word carries the opcode in bits 31:24. For register forms it carries field X in bits 23:16, Y in bits 15:8 and Z in bits 7:0. Jump forms use bits 23:0 as one signed two's-complement offset.
- R2: After synchronous reset the PC is 0, so the first fetch is from word address 0. The zero flag is clear, `halted` is 0, `exit_code` is 0, and `in_ready` and `out_valid` are low.
- R3: Opcode 0x01 sets `halted` and loads `exit_code` with the full 64-bit value of register X. After that the core fetches nothing more, and `halted`, `exit_code` and `imem_addr` hold.
- R4: Opcode 0x02 raises `in_ready` and waits until `in_valid` is seen. It then writes `in_data`, zero-extended to 64 bits, into register X.
- R5: Opcode 0x03 raises `out_valid` with `out_data` equal to bits 7:0 of register X. Both hold until `out_ready` is seen.
- R6: Opcode 0x05 writes register Y minus the zero-extended immediate X, modulo 2^64, into register Z. It sets the zero flag exactly when that result is 0.
- R7: Opcode 0x04 sets the PC to the jump's own byte address plus 4 times the signed offset. An offset of 0xFFFFFC at byte 0x10 goes to 0x00, and an offset of 3 at byte 0x08 goes to 0x14.
- R8: Opcode 0x06 branches as in R7 only when the zero flag is 0. Opcode 0x07 branches only when it is 1. When the branch is not taken, execution continues at PC+4.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: Any other opcode (0x00, 0x08 to 0xFF) halts the core with `exit_code` equal to 0xFF.
- R11: Every instruction that is not a jump continues at the next word (PC+4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IMEM_AW | Word address of the instruction being fetched |
| imem_data | input | 32 | Instruction word, valid one cycle after the address |
| in_valid | input | 1 | Input character available |
| in_ready | output | 1 | Core is waiting to take an input character |
| in_data | input | 8 | Input character |
| out_valid | output | 1 | Output character available |
| out_ready | input | 1 | Receiver takes the output character |
| out_data | output | 8 | Output character |
| halted | output | 1 | Core has stopped |
| exit_code | output | XLEN | Exit value captured at halt |

## Verification
The zero flag cannot be seen at the ports. It shows only through which path a conditional branch takes. The stimulus therefore runs small programs in which each branch outcome leads to a halt with its own exit value, so a wrong flag or a wrong branch decision appears as a wrong `exit_code`. Stalled handshakes are produced by gating `in_valid` and `out_ready` on a cycle counter while a copy loop runs, so the execute state has to wait in both directions and also pass backward jumps.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam logic [7:0] OP_HALT = 8'h01;
  localparam logic [7:0] OP_GETC = 8'h02;
  localparam logic [7:0] OP_PUTC = 8'h03;
  localparam logic [7:0] OP_JMP  = 8'h04;
  localparam logic [7:0] OP_SUBI = 8'h05;
  localparam logic [7:0] OP_JNZ  = 8'h06;
  localparam logic [7:0] OP_JZ   = 8'h07;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_HALT
  } state_e;

  typedef struct packed {
    logic halt;
    logic getc;
    logic putc;
    logic subi;
    logic jump;
    logic uncond;
    logic want_zf;
    logic bad;
    logic wr;
  } ctrl_t;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
#(
  parameter int RAW = 8
) (
  input  logic [31:0]    instr,
  output ctrl_t          ctrl,
  output logic [RAW-1:0] rd_sel,
  output logic [RAW-1:0] wr_sel
);
  logic [7:0] op, fx, fy, fz;
  assign op = instr[31:24];
  assign fx = instr[23:16];
  assign fy = instr[15:8];
  assign fz = instr[7:0];

  always_comb begin
    ctrl = '0;
    case (op)
      OP_HALT: ctrl.halt = 1'b1;
      OP_GETC: begin ctrl.getc = 1'b1; ctrl.wr = 1'b1; end
      OP_PUTC: ctrl.putc = 1'b1;
      OP_JMP:  begin ctrl.jump = 1'b1; ctrl.uncond = 1'b1; end
      OP_SUBI: begin ctrl.subi = 1'b1; ctrl.wr = 1'b1; end
      OP_JNZ:  ctrl.jump = 1'b1;
      OP_JZ:   begin ctrl.jump = 1'b1; ctrl.want_zf = 1'b1; end
      default: ctrl.bad = 1'b1;
    endcase
  end

  assign rd_sel = (op == OP_SUBI) ? RAW'(fy) : RAW'(fx);
  assign wr_sel = (op == OP_SUBI) ? RAW'(fz) : RAW'(fx);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 256,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [RAW-1:0]  rd_addr,
  output logic [XLEN-1:0] rd_data,
  input  logic            we,
  input  logic [RAW-1:0]  wr_addr,
  input  logic [XLEN-1:0] wr_data
);
  logic [XLEN-1:0] mem [NREG];
  logic [XLEN-1:0] rd_q;
  logic            zero_q;

  always_ff @(posedge clk) begin
    if (we && (wr_addr != '0))
      mem[wr_addr] <= wr_data;
    if (rd_en)
      rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)        zero_q <= 1'b1;
    else if (rd_en) zero_q <= (rd_addr == '0);
  end

  assign rd_data = zero_q ? '0 : rd_q;

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == '0) |=> (rd_data == '0));
endmodule

// File: rtl/cpu_exec.sv
module cpu_exec
  import cpu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PC_W = 12
) (
  input  ctrl_t           ctrl,
  input  logic [7:0]      imm,
  input  logic [23:0]     offset,
  input  logic [XLEN-1:0] src,
  input  logic [PC_W-1:0] pc,
  input  logic            zf,
  output logic [XLEN-1:0] diff,
  output logic            diff_zero,
  output logic            taken,
  output logic [PC_W-1:0] target
);
  logic [PC_W-1:0] off_bytes;

  assign diff      = src - XLEN'(imm);
  assign diff_zero = (diff == '0);
  assign off_bytes = PC_W'({{PC_W{offset[23]}}, offset, 2'b00});
  assign target    = pc + off_bytes;
  assign taken     = ctrl.jump && (ctrl.uncond || (zf == ctrl.want_zf));
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NREG    = 256,
  parameter int IMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]        imem_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               halted,
  output logic [XLEN-1:0]    exit_code
);
  localparam int PC_W = IMEM_AW + 2;
  localparam int RAW  = $clog2(NREG);

  state_e          st_q;
  logic [PC_W-1:0] pc_q, npc_q, target;
  logic [23:0]     ir_q;
  ctrl_t           ctrl_d, ctrl_q;
  logic [RAW-1:0]  rd_sel, wr_sel, wr_sel_q;
  logic [XLEN-1:0] rf_rdata, wb_q, diff;
  logic            diff_zero, taken, zf_q;

  cpu_decode #(.RAW(RAW)) dec_i (
    .instr(imem_data), .ctrl(ctrl_d), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  cpu_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
    .clk(clk), .rst(rst),
    .rd_en(st_q == ST_DECODE), .rd_addr(rd_sel), .rd_data(rf_rdata),
    .we(st_q == ST_WB && ctrl_q.wr), .wr_addr(wr_sel_q), .wr_data(wb_q)
  );

  cpu_exec #(.XLEN(XLEN), .PC_W(PC_W)) ex_i (
    .ctrl(ctrl_q), .imm(ir_q[23:16]), .offset(ir_q), .src(rf_rdata),
    .pc(pc_q), .zf(zf_q), .diff(diff), .diff_zero(diff_zero),
    .taken(taken), .target(target)
  );

  assign imem_addr = pc_q[PC_W-1:2];
  assign in_ready  = (st_q == ST_EXEC) && ctrl_q.getc;
  assign out_valid = (st_q == ST_EXEC) && ctrl_q.putc;
  assign out_data  = rf_rdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_FETCH;
      pc_q      <= '0;
      npc_q     <= '0;
      ir_q      <= '0;
      ctrl_q    <= '0;
      wr_sel_q  <= '0;
      wb_q      <= '0;
      zf_q      <= 1'b0;
      halted    <= 1'b0;
      exit_code <= '0;
    end else begin
      case (st_q)
        ST_FETCH: st_q <= ST_DECODE;
        ST_DECODE: begin
          ir_q     <= imem_data[23:0];
          ctrl_q   <= ctrl_d;
          wr_sel_q <= wr_sel;
          st_q     <= ST_EXEC;
        end
        ST_EXEC: begin
          npc_q <= taken ? target : pc_q + PC_W'(4);
          if (ctrl_q.bad) begin
            halted    <= 1'b1;
            exit_code <= XLEN'(8'hFF);
            st_q      <= ST_HALT;
          end else if (ctrl_q.halt) begin
            halted    <= 1'b1;
            exit_code <= rf_rdata;
            st_q      <= ST_HALT;
          end else if (ctrl_q.getc) begin
            if (in_valid) begin
              wb_q <= XLEN'(in_data);
              st_q <= ST_WB;
            end
          end else if (ctrl_q.putc) begin
            if (out_ready) st_q <= ST_WB;
          end else if (ctrl_q.subi) begin
            wb_q <= diff;
            zf_q <= diff_zero;
            st_q <= ST_WB;
          end else begin
            st_q <= ST_WB;
          end
        end
        ST_WB: begin
          pc_q <= npc_q;
          st_q <= ST_FETCH;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(exit_code) && $stable(imem_addr)));

  // R4
  in_ready_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!halted && !out_valid));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  flag_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXEC && ctrl_q.subi) |=> (zf_q == (wb_q == '0)));

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXEC && ctrl_q.bad) |=> (halted && exit_code == XLEN'(8'hFF)));

  // R11
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WB && !ctrl_q.jump) |=> (pc_q == $past(pc_q) + PC_W'(4)));
endmodule

// File: tb/cpu_core_tb.sv
module cpu_core_tb_top;
  localparam int XLEN = 64;
  localparam int AW   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_data;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, halted;
  logic [7:0] in_data = 8'h00, out_data;
  logic [XLEN-1:0] exit_code;

  always #10 clk = ~clk;

  cpu_core #(.XLEN(XLEN), .NREG(256), .IMEM_AW(AW)) dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .halted(halted), .exit_code(exit_code)
  );

  logic [31:0] mem [64];
  logic [7:0]  in_buf [8];
  logic [7:0]  out_buf [8];
  int in_len = 0, in_idx = 0, out_cnt = 0, cyc = 0;
  bit stall = 1'b0;
  int checks = 0, fails = 0;

  always @(posedge clk) imem_data <= mem[imem_addr[5:0]];

  always @(posedge clk) begin
    if (rst) begin
      in_idx  <= 0;
      out_cnt <= 0;
    end else begin
      if (in_valid && in_ready) in_idx <= in_idx + 1;
      if (out_valid && out_ready) begin
        out_buf[out_cnt[2:0]] <= out_data;
        out_cnt <= out_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    in_valid  = (in_idx < in_len) && (!stall || cyc[1:0] == 2'd0);
    in_data   = in_buf[in_idx[2:0]];
    out_ready = !stall || cyc[1:0] == 2'd2;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic run_prog();
    int n;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) check(1'b0, "timeout", 64'(n), 64'd3000);
  endtask

  typedef struct packed { logic [7:0] in_b; logic [7:0] imm; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h41, 8'h01}, '{8'h05, 8'h05}, '{8'h00, 8'hFF},
    '{8'hFF, 8'hFF}, '{8'h10, 8'h20}, '{8'h80, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] expv;
    clear_mem();
    // R2 reset state, sampled while reset is held and right after release
    repeat (3) @(negedge clk);
    check(!halted && imem_addr == 0 && !in_ready && !out_valid && exit_code == 0,
          "R2 reset", {halted, in_ready, out_valid, 61'(imem_addr)}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(imem_addr == 0 && !halted, "R2 first fetch", 64'(imem_addr), 64'd0);

    // Table: read byte, subtract immediate, branch on zero, halt with value (R1 R3 R4 R6 R8)
    foreach (VECS[k]) begin
      clear_mem();
      mem[0] = 32'h02010000;
      mem[1] = {8'h05, VECS[k].imm, 8'h01, 8'h02};
      mem[2] = 32'h07000002;
      mem[3] = 32'h01020000;
      mem[4] = 32'h05050003;
      mem[5] = 32'h01030000;
      in_buf[0] = VECS[k].in_b;
      in_len = 1;
      run_prog();
      expv = (VECS[k].in_b == VECS[k].imm) ? 64'hFFFF_FFFF_FFFF_FFFB
             : 64'(VECS[k].in_b) - 64'(VECS[k].imm);
      check(halted && exit_code == expv, "R6 R8 R4 subtract/branch", exit_code, expv);
    end

    // Copy loop with stalls on both handshakes (R5 R4 R7 R11)
    clear_mem();
    mem[0] = 32'h02040000;
    mem[1] = 32'h05FF0407;
    mem[2] = 32'h07000003;
    mem[3] = 32'h03040000;
    mem[4] = 32'h04FFFFFC;
    mem[5] = 32'h01000000;
    in_buf[0] = 8'h48; in_buf[1] = 8'h69; in_buf[2] = 8'h21; in_buf[3] = 8'hFF;
    in_len = 4;
    stall = 1'b1;
    run_prog();
    stall = 1'b0;
    check(out_cnt == 3, "R5 output count", 64'(out_cnt), 64'd3);
    check(out_buf[0] == 8'h48 && out_buf[1] == 8'h69 && out_buf[2] == 8'h21, "R5 output bytes",
          {40'd0, out_buf[0], out_buf[1], out_buf[2]}, 64'h486921);
    check(in_idx == 4, "R4 inputs consumed", 64'(in_idx), 64'd4);
    check(exit_code == 0, "R7 loop exit", exit_code, 64'd0);

    // R8 branch-if-nonzero: not taken with flag set, taken with flag clear
    clear_mem();
    mem[0] = 32'h05000001;
    mem[1] = 32'h06000004;
    mem[2] = 32'h05030005;
    mem[3] = 32'h06000002;
    mem[5] = 32'h01050000;
    in_len = 0;
    run_prog();
    check(exit_code == 64'hFFFF_FFFF_FFFF_FFFD, "R8 jnz paths", exit_code, 64'hFFFF_FFFF_FFFF_FFFD);

    // R9 writes to register 0 discarded
    clear_mem();
    mem[0] = 32'h05010000;
    mem[1] = 32'h05000006;
    mem[2] = 32'h01060000;
    run_prog();
    check(exit_code == 0, "R9 zero register", exit_code, 64'd0);

    // R10 undefined opcodes 0x08 and 0x00
    clear_mem();
    mem[0] = 32'h08000000;
    run_prog();
    check(exit_code == 64'hFF, "R10 opcode 08", exit_code, 64'hFF);
    clear_mem();
    mem[0] = 32'h05000001;
    run_prog();
    check(exit_code == 64'hFF && imem_addr == 1, "R10 opcode 00", exit_code, 64'hFF);

    // R3 halted state holds
    repeat (10) @(negedge clk);
    check(halted && imem_addr == 1 && exit_code == 64'hFF, "R3 halt holds",
          {63'(imem_addr), halted}, 64'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule